// File: doc/BRIEF.md
# Page Hamming Parity Engine

This block watches the data strobes of a NAND flash interface while a page is read or written. It builds a Hamming-style parity code over the whole page in a single step. The code is two 16-bit values: a position parity and its inverse. Before a page program, the host restarts the engine in compute mode, streams the page, reads both parity registers and writes them to the flash as four code bytes.

Before a page read, the host restarts the engine in verify mode. It streams the page data and then, with no gap in the stream, the four stored code bytes. The engine compares the stored code with the recomputed one and reports one of four outcomes: clean, a single data-bit error with its packed word and bit position, a single flipped bit inside the stored code, or an uncorrectable pattern. An erased page (all ones, code bytes included) reads as the uncorrectable outcome with an all-ones location, so the host can recognise it. The engine does not correct anything. The host flips the reported bit itself.

Top module: `pecc_top`

## Requirements
- R1: Register 0 (configuration) is fully readable and writable. Bits [1:0] select the data bytes per page: 0 = 512, 1 = 1024, 2 = 2048, 3 = 4096. Bit [2] selects 16-bit words (1) or 8-bit words (0). Bit [3] selects verify mode (1) or compute mode (0). The geometry is taken at each restart.
- R2: Any write to register 1 restarts the engine. At the next edge the word count, both parities, the captured code and the status are cleared.
- R3: Each data word strobed at word index w adds a 16-bit position {w[11:0], bit[3:0]} for every set bit. Register 2 reads the XOR of all such positions. Register 3 reads the XOR of their bitwise complements.
- R4: One strobe carries one word. There are bytes/1 words in 8-bit mode and bytes/2 words in 16-bit mode. In 8-bit mode, data_in[15:8] has no effect.
- R5: In verify mode, the strobes after the data carry the stored code. In 8-bit mode the byte order is parity low, parity high, inverse low, inverse high. In 16-bit mode the first word is the parity and the second is the inverse. Compute mode never produces a verdict.
- R6: Reading register 1 returns the status: bit0 = any error, bit1 = error in the code field, bit2 = uncorrectable, bit3 = checked. The status is valid from the clock edge that captures the last code strobe and holds until the next restart.
- R7: A single flipped data bit sets bit0 alone. After the check, register 2 reads that bit's {word, bit} location.
- R8: A single flipped bit in the stored code sets bit0 and bit1. Register 2 reads 0.
- R9: Any other mismatch, including an erased all-ones page, sets bit0 and bit2. Register 2 reads 16'hFFFF.
- R10: Strobes beyond the data words (compute mode) or beyond the code words (verify mode) change no register.
- R11: After reset, every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Register write address |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_addr | input | 2 | Register read address |
| reg_rd_data | output | 16 | Register read data (combinational) |
| data_stb | input | 1 | One flash data word is on data_in |
| data_in | input | 16 | Flash data word |

## Verification
The parity registers take their final value at the edge that captures the last data strobe. The verdict and location appear at the edge that captures the last code strobe. A restart clears everything at the edge of the control write. The bench updates its expected status only after the edge on which the design must change, and compares the status on every falling edge. Parity and location reads are sampled on a falling edge after the read address has settled. Extra strobes are then sent, and the same registers are read again.

// File: rtl/pecc_pkg.sv
// Shared definitions for the page parity engine.
// Assumes a 2-bit register address space.
package pecc_pkg;
    typedef enum logic [1:0] {
        RA_CFG  = 2'd0,
        RA_CTRL = 2'd1,
        RA_PAR  = 2'd2,
        RA_NPAR = 2'd3
    } reg_addr_e;

    // Configuration field positions.
    localparam int CFG_SIZE_LSB = 0;
    localparam int CFG_WIDE_BIT = 2;
    localparam int CFG_VERI_BIT = 3;
endpackage

// File: rtl/pecc_regs.sv
// Configuration register and restart decode.
// Assumes a write takes effect at the clock edge where reg_wr_en is high.
module pecc_regs
    import pecc_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q,
    output logic             restart
);
    // Any write to the control address restarts the page.
    assign restart = wr_en && (wr_addr == RA_CTRL);

    // Hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (wr_en && wr_addr == RA_CFG)
            cfg_q <= wr_data;
    end

    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_CFG) |=> cfg_q == $past(wr_data));
endmodule

// File: rtl/pecc_accum.sv
// Word counter, parity accumulators and stored-code capture.
// Assumes DW == WA + log2(DW), so that one 16-bit code word equals one data word.
// The geometry (size, width, mode) is latched at restart.
module pecc_accum #(
    parameter int WA = 12,
    parameter int DW = 16,
    localparam int BW = $clog2(DW),
    localparam int LOC_W = WA + BW,
    localparam int CNT_W = WA + 1,
    localparam int HALF = DW / 2,
    localparam int BASE_BYTES = 2 ** (WA - 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [1:0]         cfg_size,
    input  logic               cfg_wide,
    input  logic               cfg_verify,
    input  logic               stb,
    input  logic [DW-1:0]      din,
    output logic [LOC_W-1:0]   par_q,
    output logic [LOC_W-1:0]   npar_q,
    output logic [2*LOC_W-1:0] stored_q,
    output logic               checked_q
);
    logic [1:0]       size_q;
    logic             wide_q, verify_q;
    logic [CNT_W-1:0] cnt_q, n_words, n_end;
    logic [DW-1:0]    dm;
    logic [BW-1:0]    bitx;
    logic             odd, in_data, in_code, last_code;
    logic [LOC_W-1:0] contrib, ncontrib;
    logic [1:0]       slot;

    // Page geometry in words: the data count and the end of the code field.
    always_comb begin
        n_words = CNT_W'(BASE_BYTES) << size_q;
        if (wide_q)
            n_words = n_words >> 1;
        n_end = n_words + (wide_q ? CNT_W'(2) : CNT_W'(4));
    end

    // Classify the current strobe as a data word or a code word.
    assign in_data   = stb && (cnt_q < n_words);
    assign in_code   = stb && verify_q && (cnt_q >= n_words) && (cnt_q < n_end);
    assign last_code = in_code && (cnt_q == n_end - CNT_W'(1));
    assign slot      = 2'(cnt_q - n_words);

    // Position contribution of one word: XOR of set-bit indices, plus the word index when the bit count is odd.
    always_comb begin
        dm   = cfg_wide_mask(din, wide_q);
        bitx = '0;
        for (int i = 0; i < DW; i++)
            if (dm[i])
                bitx = bitx ^ i[BW-1:0];
        odd      = ^dm;
        contrib  = {odd ? cnt_q[WA-1:0] : {WA{1'b0}}, bitx};
        ncontrib = contrib ^ {LOC_W{odd}};
    end

    function automatic logic [DW-1:0] cfg_wide_mask(input logic [DW-1:0] d, input logic w);
        return w ? d : {{HALF{1'b0}}, d[HALF-1:0]};
    endfunction

    // Latch the geometry and keep the counter, parities and captured code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q    <= '0;
            wide_q    <= 1'b0;
            verify_q  <= 1'b0;
            cnt_q     <= '0;
            par_q     <= '0;
            npar_q    <= '0;
            stored_q  <= '0;
            checked_q <= 1'b0;
        end else if (restart) begin
            size_q    <= cfg_size;
            wide_q    <= cfg_wide;
            verify_q  <= cfg_verify;
            cnt_q     <= '0;
            par_q     <= '0;
            npar_q    <= '0;
            stored_q  <= '0;
            checked_q <= 1'b0;
        end else begin
            if (in_data || in_code)
                cnt_q <= cnt_q + CNT_W'(1);
            if (in_data) begin
                par_q  <= par_q ^ contrib;
                npar_q <= npar_q ^ ncontrib;
            end
            if (in_code) begin
                if (wide_q)
                    stored_q[int'(slot[0]) * DW +: DW] <= din;
                else
                    stored_q[int'(slot) * HALF +: HALF] <= din[HALF-1:0];
            end
            if (last_code)
                checked_q <= 1'b1;
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= n_end);
    // R2
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0 && !checked_q && par_q == '0 && npar_q == '0));
    // R6
    verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (checked_q && !restart) |=> checked_q);
    // R5
    compute_no_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !verify_q |-> !checked_q);
endmodule

// File: rtl/pecc_judge.sv
// Compares recomputed and stored codes and classifies the difference.
// Purely combinational. Stored layout is {inverse, parity}.
module pecc_judge #(
    parameter int LOC_W = 16
) (
    input  logic [LOC_W-1:0]   par,
    input  logic [LOC_W-1:0]   npar,
    input  logic [2*LOC_W-1:0] stored,
    output logic               data_err,
    output logic               code_err,
    output logic               multi_err,
    output logic [LOC_W-1:0]   loc
);
    logic [LOC_W-1:0] dp, dn;

    // Syndromes and their classification.
    always_comb begin
        dp        = par ^ stored[LOC_W-1:0];
        dn        = npar ^ stored[2*LOC_W-1:LOC_W];
        data_err  = (dp ^ dn) == {LOC_W{1'b1}};
        code_err  = $countones({dp, dn}) == 1;
        multi_err = ({dp, dn} != '0) && !data_err && !code_err;
        if (data_err)
            loc = dp;
        else if (multi_err)
            loc = '1;
        else
            loc = '0;
    end
endmodule

// File: rtl/pecc_top.sv
// Page parity engine top: register file, accumulator, verdict logic and read mux.
// Assumes the host restarts before each page and streams code words right after data.
module pecc_top
    import pecc_pkg::*;
#(
    parameter int WA = 12,
    parameter int DW = 16,
    localparam int LOC_W = WA + $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_wr_addr,
    input  logic [LOC_W-1:0] reg_wr_data,
    input  logic [1:0]    reg_rd_addr,
    output logic [LOC_W-1:0] reg_rd_data,
    input  logic          data_stb,
    input  logic [DW-1:0] data_in
);
    logic [LOC_W-1:0]   cfg_q, par_q, npar_q, loc;
    logic [2*LOC_W-1:0] stored_q;
    logic               restart, checked_q, data_err, code_err, multi_err;
    logic [3:0]         status;

    pecc_regs #(.REG_W(LOC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
        .wr_data(reg_wr_data), .cfg_q(cfg_q), .restart(restart)
    );

    pecc_accum #(.WA(WA), .DW(DW)) u_accum (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .cfg_size(cfg_q[CFG_SIZE_LSB +: 2]), .cfg_wide(cfg_q[CFG_WIDE_BIT]),
        .cfg_verify(cfg_q[CFG_VERI_BIT]), .stb(data_stb), .din(data_in),
        .par_q(par_q), .npar_q(npar_q), .stored_q(stored_q), .checked_q(checked_q)
    );

    pecc_judge #(.LOC_W(LOC_W)) u_judge (
        .par(par_q), .npar(npar_q), .stored(stored_q),
        .data_err(data_err), .code_err(code_err), .multi_err(multi_err), .loc(loc)
    );

    // Status word: flags are shown only once the code has been checked.
    assign status = {checked_q, checked_q & multi_err, checked_q & code_err,
                     checked_q & (data_err | code_err | multi_err)};

    // Register read mux.
    always_comb begin
        case (reg_rd_addr)
            RA_CFG:  reg_rd_data = cfg_q;
            RA_CTRL: reg_rd_data = LOC_W'(status);
            RA_PAR:  reg_rd_data = checked_q ? loc : par_q;
            default: reg_rd_data = npar_q;
        endcase
    end

    // R6
    verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checked_q |-> $onehot0({data_err, code_err, multi_err}));
    // R9
    multi_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (checked_q && multi_err) |-> loc == {LOC_W{1'b1}});
    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_q == '0 && !checked_q && par_q == '0));
endmodule

// File: tb/tb_pecc_top.sv
module tb_pecc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_addr = '0;
    logic [15:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_addr = 2'd1;
    logic [15:0] reg_rd_data;
    logic        data_stb = 1'b0;
    logic [15:0] data_in = '0;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_status = '0;
    logic [15:0] page_mem [4096];
    bit finished = 0;

    pecc_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .data_stb(data_stb), .data_in(data_in)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Per-clock reference comparison of the status word (R6).
    always @(negedge clk)
        if (rst_n && reg_rd_addr == 2'd1 && !finished)
            chk("R6 status", reg_rd_data, exp_status);

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        summary();
    end

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        reg_rd_addr = a;
        @(negedge clk);
        v = reg_rd_data;
        @(posedge clk); #1;
        reg_rd_addr = 2'd1;
    endtask

    task automatic strobe(input logic [15:0] d);
        data_stb = 1'b1; data_in = d;
        @(posedge clk); #1;
        data_stb = 1'b0;
    endtask

    // Model: XOR of positions and complemented positions over the page.
    task automatic model_code(input int nw, input bit wide, output logic [15:0] p, output logic [15:0] np);
        p = '0; np = '0;
        for (int w = 0; w < nw; w++)
            for (int b = 0; b < (wide ? 16 : 8); b++)
                if (page_mem[w][b]) begin
                    p  = p ^ {w[11:0], b[3:0]};
                    np = np ^ ~{w[11:0], b[3:0]};
                end
    endtask

    task automatic fill(input int nw, input bit wide, input int seed, input bit erased);
        for (int i = 0; i < nw; i++) begin
            page_mem[i] = erased ? 16'hFFFF : 16'((i * 37) ^ (seed * 1103) ^ ((i >> 3) * 5));
            if (!wide) page_mem[i][15:8] = 8'h00;
        end
    endtask

    // In 8-bit mode the upper lane carries junk that must be ignored (R4).
    task automatic send_page(input int nw, input bit wide);
        for (int i = 0; i < nw; i++)
            strobe(wide ? page_mem[i] : {8'(i * 7 + 3), page_mem[i][7:0]});
    endtask

    task automatic run_compute(input int size, input bit wide, input int seed, input string tag);
        int nw;
        logic [15:0] p, np, v;
        nw = (512 << size) >> wide;
        fill(nw, wide, seed, 0);
        model_code(nw, wide, p, np);
        wr_reg(2'd0, {12'h000, 1'b0, wide, size[1:0]});
        wr_reg(2'd1, 16'h0);
        exp_status = '0;
        send_page(nw, wide);
        rd_reg(2'd2, v); chk({tag, " R3 parity"}, v, p);
        rd_reg(2'd3, v); chk({tag, " R3 inverse"}, v, np);
        strobe(16'h1234); strobe(16'hBEEF); strobe(16'h0F0F);
        rd_reg(2'd2, v); chk({tag, " R10 parity after extra"}, v, p);
        rd_reg(2'd3, v); chk({tag, " R10 inverse after extra"}, v, np);
    endtask

    task automatic run_verify(input int size, input bit wide, input int seed,
                              input int w0, input int b0, input int w1, input int b1,
                              input int cbit, input bit erased,
                              input logic [15:0] exp_st, input logic [15:0] exp_loc,
                              input string tag);
        int nw;
        logic [15:0] p, np, v;
        logic [31:0] code;
        nw = (512 << size) >> wide;
        fill(nw, wide, seed, erased);
        model_code(nw, wide, p, np);
        code = erased ? 32'hFFFF_FFFF : {np, p};
        if (cbit >= 0) code[cbit] = ~code[cbit];
        if (w0 >= 0) page_mem[w0][b0] = ~page_mem[w0][b0];
        if (w1 >= 0) page_mem[w1][b1] = ~page_mem[w1][b1];
        wr_reg(2'd0, {12'h000, 1'b1, wide, size[1:0]});
        wr_reg(2'd1, 16'h0);
        exp_status = '0;
        send_page(nw, wide);
        if (wide) begin
            strobe(code[15:0]); strobe(code[31:16]);
        end else begin
            strobe({8'hC3, code[7:0]});   strobe({8'h3C, code[15:8]});
            strobe({8'h99, code[23:16]}); strobe({8'h66, code[31:24]});
        end
        exp_status = exp_st;
        rd_reg(2'd2, v); chk({tag, " location"}, v, exp_loc);
        strobe(16'hFFFF); strobe(16'h0001);
        rd_reg(2'd2, v); chk({tag, " R10 location after extra"}, v, exp_loc);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R11 reset values
        rd_reg(2'd0, v); chk("R11 cfg", v, 16'h0);
        rd_reg(2'd1, v); chk("R11 status", v, 16'h0);
        rd_reg(2'd2, v); chk("R11 parity", v, 16'h0);
        rd_reg(2'd3, v); chk("R11 inverse", v, 16'h0);
        // R1 readback of every bit
        wr_reg(2'd0, 16'hA5F3);
        rd_reg(2'd0, v); chk("R1 cfg readback", v, 16'hA5F3);
        // R3/R4 compute mode, both widths
        run_compute(0, 0, 1, "R4 8bit");
        run_compute(1, 1, 2, "R4 16bit");
        // R5 clean verify
        run_verify(0, 0, 3, -1, 0, -1, 0, -1, 0, 16'h8, 16'h0, "R5 clean");
        // R7 single data errors
        run_verify(0, 0, 4, 300, 5, -1, 0, -1, 0, 16'h9, {12'd300, 4'd5}, "R7 mid");
        run_verify(0, 0, 5, 0, 0, -1, 0, -1, 0, 16'h9, 16'h0000, "R7 first bit");
        run_verify(1, 1, 6, 511, 15, -1, 0, -1, 0, 16'h9, {12'd511, 4'd15}, "R7 wide last");
        run_verify(2, 0, 7, 2047, 7, -1, 0, -1, 0, 16'h9, {12'd2047, 4'd7}, "R7 2k");
        run_verify(3, 0, 8, 4095, 0, -1, 0, -1, 0, 16'h9, 16'hFFF0, "R7 4k");
        // R8 code field errors
        run_verify(0, 0, 9, -1, 0, -1, 0, 17, 0, 16'hB, 16'h0, "R8 inverse bit");
        run_verify(1, 1, 10, -1, 0, -1, 0, 3, 0, 16'hB, 16'h0, "R8 parity bit wide");
        // R9 uncorrectable and erased
        run_verify(0, 0, 11, 10, 1, 20, 6, -1, 0, 16'hD, 16'hFFFF, "R9 double");
        run_verify(0, 0, 0, -1, 0, -1, 0, -1, 1, 16'hD, 16'hFFFF, "R9 erased 8bit");
        run_verify(2, 1, 0, -1, 0, -1, 0, -1, 1, 16'hD, 16'hFFFF, "R9 erased 16bit");
        // R2 restart clears the verdict
        wr_reg(2'd1, 16'h0);
        exp_status = '0;
        rd_reg(2'd2, v); chk("R2 parity cleared", v, 16'h0);
        rd_reg(2'd3, v); chk("R2 inverse cleared", v, 16'h0);
        summary();
    end
endmodule